// File: doc/BRIEF.md
# Host-Coprocessor Mailbox Latch Bridge

This block passes single bytes in both directions between a host on an 8-bit PC-style I/O bus and an 8-bit coprocessor on the same card. Each direction has its own one-byte latch and its own pending flag. The command latch runs from the host to the coprocessor. The reply latch runs back from the coprocessor to the host. Writing a latch raises its flag. Reading that latch from the other side drops the flag. While a command is waiting, the coprocessor's non-maskable interrupt request is held high.

On the host side the block answers a pair of adjacent I/O ports. Their base is `0x100 + 0x10 * s`, where `s` is a 4-bit switch value that is captured only while reset is high. The even port carries the data in both directions. A read of the odd port returns a status bit that is low when a reply is waiting. On the coprocessor side the block answers every address from 0x7F00 to 0x7FFF. A read there fetches the command, and a write there stores a reply.

The bus strobes are single-cycle pulses with no back-pressure: each strobe is complete in its own clock cycle. Read data is valid combinationally during the cycle of the read strobe. A flag changes at the clock edge that ends the strobe's cycle.

Top module: `mbx_bridge`

## Requirements
- R1: The host window base is 0x100 + 0x10 × `host_sw`, captured while `rst` is high. With the switch at 7 the base is 0x170. Only base and base+1 are decoded. Strobes at any other host address have no effect and return 0.
- R2: A host write to base (offset 0) loads `host_wdata` into the command latch and sets the command-pending flag at that clock edge.
- R3: `cp_nmi` is high exactly while the command-pending flag is set.
- R4: A coprocessor read at any address whose bits 15:8 are 0x7F returns the command byte in the same cycle and clears the command-pending flag at that edge. Bits 7:0 of the address are ignored.
- R5: A coprocessor write at any address whose bits 15:8 are 0x7F loads the reply latch and sets the reply-pending flag.
- R6: A host read at base returns the reply byte in the same cycle and clears the reply-pending flag at that edge.
- R7: A host read at base+1 returns bit 0 equal to the inverse of reply-pending, with bits 7:1 at 0. Such a read changes no state.
- R8: A host write at base+1 is ignored. The command byte and the command-pending flag are unchanged.
- R9: Changing `host_sw` while `rst` is low does not move the window.
- R10: Reset clears both latches and both flags to 0, so `cp_nmi` is low and the status read returns 1.
- R11: When a latch is written and read from the opposite side in the same cycle, the write wins. The read returns the old byte, and the flag stays set with the new byte held.
- R12: `host_rdata` and `cp_rdata` are 0 in any cycle without a decoded read strobe on their side.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also captures `host_sw` |
| host_sw | input | 4 | Window select switch |
| host_addr | input | 10 | Host I/O address |
| host_rd | input | 1 | Host read strobe, one cycle |
| host_wr | input | 1 | Host write strobe, one cycle |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data, valid during `host_rd` |
| cp_addr | input | 16 | Coprocessor address |
| cp_rd | input | 1 | Coprocessor read strobe, one cycle |
| cp_wr | input | 1 | Coprocessor write strobe, one cycle |
| cp_wdata | input | 8 | Coprocessor write data |
| cp_rdata | output | 8 | Coprocessor read data, valid during `cp_rd` |
| cp_nmi | output | 1 | Non-maskable interrupt request to the coprocessor |

## Verification
The bench uses the default parameters: an 8-bit data path, a 10-bit host address, a 4-bit switch and a 16-bit coprocessor address with an ignored low byte. It resets with the switch at 7, then at 0, then at 15. This covers the lowest, middle and highest windows, and it tries addresses one below and one above each window. Each mirror page is reached at both of its ends, at 0x7F00 and 0x7FFF, and at a middle offset. Same-cycle write-and-read collisions are driven on both latches.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  typedef enum logic [1:0] {
    HSEL_NONE = 2'd0,
    HSEL_DATA = 2'd1,
    HSEL_STAT = 2'd2
  } hsel_e;
endpackage

// File: rtl/mbx_latch.sv
// One-byte mailbox slot with a pending flag; a load wins over a take.
module mbx_latch #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [DW-1:0] load_data,
  input  logic          take,
  output logic [DW-1:0] q,
  output logic          pend
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q    <= '0;
      pend <= 1'b0;
    end else if (load) begin
      q    <= load_data;
      pend <= 1'b1;
    end else if (take) begin
      pend <= 1'b0;
    end
  end
endmodule

// File: rtl/mbx_host_if.sv
// Host window: base captured from the switch during reset, two ports decoded.
module mbx_host_if
  import mbx_pkg::*;
#(
  parameter int AW        = 10,
  parameter int SW_W      = 4,
  parameter int BASE_ORG  = 256,
  parameter int BASE_STEP = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [SW_W-1:0] sw,
  input  logic [AW-1:0]   addr,
  input  logic            rd,
  input  logic            wr,
  output logic            cmd_load,
  output logic            rep_take,
  output hsel_e           rsel,
  output logic [AW-1:0]   base_q
);
  localparam logic [AW-1:0] ORG  = AW'(BASE_ORG);
  localparam logic [AW-1:0] STEP = AW'(BASE_STEP);

  logic hit;
  logic odd;

  always_ff @(posedge clk) begin
    if (rst) base_q <= ORG + AW'(sw) * STEP;
  end

  assign hit = (addr[AW-1:1] == base_q[AW-1:1]);
  assign odd = addr[0];

  assign cmd_load = !rst && wr && hit && !odd;
  assign rep_take = !rst && rd && hit && !odd;

  always_comb begin
    rsel = HSEL_NONE;
    if (rd && hit) rsel = odd ? HSEL_STAT : HSEL_DATA;
  end
endmodule

// File: rtl/mbx_cp_if.sv
// Coprocessor side: one mirrored page, low address bits ignored.
module mbx_cp_if #(
  parameter int AW   = 16,
  parameter int IGN  = 8,
  parameter int PAGE = 127
) (
  input  logic          rst,
  input  logic [AW-1:0] addr,
  input  logic          rd,
  input  logic          wr,
  output logic          hit_rd,
  output logic          hit_wr
);
  localparam int PW = AW - IGN;
  localparam logic [PW-1:0] PAGE_V = PW'(PAGE);

  logic page_hit;

  assign page_hit = (addr[AW-1:IGN] == PAGE_V);
  assign hit_rd   = !rst && rd && page_hit;
  assign hit_wr   = !rst && wr && page_hit;
endmodule

// File: rtl/mbx_bridge.sv
module mbx_bridge
  import mbx_pkg::*;
#(
  parameter int DW        = 8,
  parameter int HOST_AW   = 10,
  parameter int SW_W      = 4,
  parameter int BASE_ORG  = 256,
  parameter int BASE_STEP = 16,
  parameter int CP_AW     = 16,
  parameter int CP_IGN    = 8,
  parameter int CP_PAGE   = 127
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [SW_W-1:0]    host_sw,
  input  logic [HOST_AW-1:0] host_addr,
  input  logic               host_rd,
  input  logic               host_wr,
  input  logic [DW-1:0]      host_wdata,
  output logic [DW-1:0]      host_rdata,
  input  logic [CP_AW-1:0]   cp_addr,
  input  logic               cp_rd,
  input  logic               cp_wr,
  input  logic [DW-1:0]      cp_wdata,
  output logic [DW-1:0]      cp_rdata,
  output logic               cp_nmi
);
  logic               cmd_load, rep_take;
  hsel_e              rsel;
  logic [HOST_AW-1:0] base_q;
  logic               cp_hit_rd, cp_hit_wr;
  logic [DW-1:0]      cmd_q, rep_q;
  logic               cmd_pend, rep_pend;

  mbx_host_if #(
    .AW(HOST_AW), .SW_W(SW_W), .BASE_ORG(BASE_ORG), .BASE_STEP(BASE_STEP)
  ) host_i (
    .clk(clk), .rst(rst), .sw(host_sw), .addr(host_addr),
    .rd(host_rd), .wr(host_wr),
    .cmd_load(cmd_load), .rep_take(rep_take), .rsel(rsel), .base_q(base_q)
  );

  mbx_cp_if #(.AW(CP_AW), .IGN(CP_IGN), .PAGE(CP_PAGE)) cp_i (
    .rst(rst), .addr(cp_addr), .rd(cp_rd), .wr(cp_wr),
    .hit_rd(cp_hit_rd), .hit_wr(cp_hit_wr)
  );

  // host -> coprocessor
  mbx_latch #(.DW(DW)) cmd_i (
    .clk(clk), .rst(rst), .load(cmd_load), .load_data(host_wdata),
    .take(cp_hit_rd), .q(cmd_q), .pend(cmd_pend)
  );

  // coprocessor -> host
  mbx_latch #(.DW(DW)) rep_i (
    .clk(clk), .rst(rst), .load(cp_hit_wr), .load_data(cp_wdata),
    .take(rep_take), .q(rep_q), .pend(rep_pend)
  );

  always_comb begin
    unique case (rsel)
      HSEL_DATA: host_rdata = rep_q;
      HSEL_STAT: host_rdata = {{(DW-1){1'b0}}, ~rep_pend};
      default:   host_rdata = '0;
    endcase
  end

  assign cp_rdata = cp_hit_rd ? cmd_q : '0;
  assign cp_nmi   = cmd_pend;
endmodule

// File: rtl/mbx_bridge_chk.sv
module mbx_bridge_chk #(
  parameter int DW      = 8,
  parameter int HOST_AW = 10,
  parameter int CP_AW   = 16,
  parameter int CP_IGN  = 8,
  parameter int CP_PAGE = 127
) (
  input logic               clk,
  input logic               rst,
  input logic [HOST_AW-1:0] host_addr,
  input logic               host_rd,
  input logic               host_wr,
  input logic [CP_AW-1:0]   cp_addr,
  input logic               cp_rd,
  input logic               cp_wr,
  input logic               cp_nmi,
  input logic [HOST_AW-1:0] base_q,
  input logic               rep_pend
);
  localparam int PW = CP_AW - CP_IGN;
  localparam logic [PW-1:0] PAGE_V = PW'(CP_PAGE);

  logic cp_pg, h_even, h_odd;
  assign cp_pg  = (cp_addr[CP_AW-1:CP_IGN] == PAGE_V);
  assign h_even = (host_addr == base_q);
  assign h_odd  = (host_addr == base_q + HOST_AW'(1));

  // R2
  cmd_set_chk: assert property (@(posedge clk) disable iff (rst)
    (host_wr && h_even) |=> cp_nmi);

  // R4
  cmd_take_chk: assert property (@(posedge clk) disable iff (rst)
    (cp_rd && cp_pg && !(host_wr && h_even)) |=> !cp_nmi);

  // R3
  nmi_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(cp_nmi) |-> $past(host_wr && h_even));

  // R6
  rep_take_chk: assert property (@(posedge clk) disable iff (rst)
    (host_rd && h_even && !(cp_wr && cp_pg)) |=> !rep_pend);

  // R7
  stat_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (host_rd && h_odd && !(cp_wr && cp_pg)) |=> $stable(rep_pend));

  // R8
  odd_wr_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (host_wr && h_odd && !(cp_rd && cp_pg)) |=> $stable(cp_nmi));

  // R9
  base_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rst |=> $stable(base_q));
endmodule

bind mbx_bridge mbx_bridge_chk #(
  .DW(DW), .HOST_AW(HOST_AW), .CP_AW(CP_AW), .CP_IGN(CP_IGN), .CP_PAGE(CP_PAGE)
) chk_i (
  .clk(clk), .rst(rst), .host_addr(host_addr), .host_rd(host_rd),
  .host_wr(host_wr), .cp_addr(cp_addr), .cp_rd(cp_rd), .cp_wr(cp_wr),
  .cp_nmi(cp_nmi), .base_q(base_q), .rep_pend(rep_pend)
);

// File: tb/mbx_bridge_tb.sv
module mbx_bridge_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  host_sw = 4'd7;
  logic [9:0]  host_addr = '0;
  logic        host_rd = 1'b0, host_wr = 1'b0;
  logic [7:0]  host_wdata = '0;
  logic [7:0]  host_rdata;
  logic [15:0] cp_addr = '0;
  logic        cp_rd = 1'b0, cp_wr = 1'b0;
  logic [7:0]  cp_wdata = '0;
  logic [7:0]  cp_rdata;
  logic        cp_nmi;

  always #4 clk = ~clk;

  mbx_bridge dut_i (
    .clk(clk), .rst(rst), .host_sw(host_sw), .host_addr(host_addr),
    .host_rd(host_rd), .host_wr(host_wr), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .cp_addr(cp_addr), .cp_rd(cp_rd), .cp_wr(cp_wr),
    .cp_wdata(cp_wdata), .cp_rdata(cp_rdata), .cp_nmi(cp_nmi)
  );

  int    n_chk = 0, n_bad = 0;
  bit    done = 1'b0;
  string tag = "R10";

  // behavioural reference state
  int        m_base = 0;
  bit [7:0]  m_cmd = 0, m_rep = 0;
  bit        m_cmdp = 0, m_repp = 0;

  task automatic tick();
    bit [7:0] eh, ec;
    bit       en, hd, ho, cpg;
    #2;
    hd  = (int'(host_addr) == m_base);
    ho  = (int'(host_addr) == m_base + 1);
    cpg = (cp_addr[15:8] == 8'h7F);
    if (!rst) begin
      eh = 8'h00;
      if (host_rd && hd) eh = m_rep;
      else if (host_rd && ho) eh = {7'b0, !m_repp};
      ec = (cp_rd && cpg) ? m_cmd : 8'h00;
      en = m_cmdp;
      n_chk++;
      if (host_rdata !== eh || cp_rdata !== ec || cp_nmi !== en) begin
        n_bad++;
        $display("FAIL %s: host_rdata=%h exp %h, cp_rdata=%h exp %h, cp_nmi=%b exp %b",
                 tag, host_rdata, eh, cp_rdata, ec, cp_nmi, en);
      end
    end
    @(posedge clk);
    if (rst) begin
      m_cmd = 0; m_rep = 0; m_cmdp = 0; m_repp = 0;
      m_base = 256 + 16 * int'(host_sw);
    end else begin
      if (host_wr && hd) begin m_cmd = host_wdata; m_cmdp = 1; end
      else if (cp_rd && cpg) m_cmdp = 0;
      if (cp_wr && cpg) begin m_rep = cp_wdata; m_repp = 1; end
      else if (host_rd && hd) m_repp = 0;
    end
    @(negedge clk);
  endtask

  task automatic clear_in();
    host_rd = 0; host_wr = 0; cp_rd = 0; cp_wr = 0;
  endtask

  task automatic hw(input int a, input bit [7:0] d);
    host_addr = 10'(a); host_wdata = d; host_wr = 1; tick(); clear_in();
  endtask
  task automatic hr(input int a);
    host_addr = 10'(a); host_rd = 1; tick(); clear_in();
  endtask
  task automatic cw(input bit [15:0] a, input bit [7:0] d);
    cp_addr = a; cp_wdata = d; cp_wr = 1; tick(); clear_in();
  endtask
  task automatic cr(input bit [15:0] a);
    cp_addr = a; cp_rd = 1; tick(); clear_in();
  endtask
  task automatic do_reset(input bit [3:0] s);
    rst = 1; host_sw = s;
    for (int i = 0; i < 3; i++) tick();
    rst = 0;
  endtask

  task automatic window_pass(input int b);
    tag = "R1";  hw(b - 1, 8'h11); hw(b + 2, 8'h12); hr(b - 1); hr(b + 2);
    tag = "R2";  hw(b, 8'h3C);
    tag = "R3";  tick();
    tag = "R4";  cr(16'h7F00);
    tag = "R5";  cw(16'h7FFF, 8'hC3);
    tag = "R7";  hr(b + 1); hr(b + 1);
    tag = "R6";  hr(b); hr(b + 1);
  endtask

  initial begin
    #1;
    @(negedge clk);
    do_reset(4'd7);
    tag = "R10"; hr(16'h171); tick();
    tag = "R12"; hr(16'h16F); cr(16'h7E55); tick();
    tag = "R1";  hw(16'h16F, 8'hEE); hw(16'h172, 8'hEF); hw(16'h180, 8'hF0);
    tag = "R2";  hw(16'h170, 8'hA5);
    tag = "R3";  tick(); tick();
    tag = "R12"; cr(16'h807F); cr(16'h7E00);
    tag = "R4";  cr(16'h7F3C); tick();
    tag = "R8";  hw(16'h171, 8'h99); cr(16'h7F80);
    tag = "R5";  cw(16'h7E10, 8'h77); hr(16'h171); cw(16'h7F42, 8'h5A);
    tag = "R7";  hr(16'h171); hr(16'h171);
    tag = "R6";  hr(16'h170); hr(16'h171); hr(16'h170);
    tag = "R9";  host_sw = 4'd3; tick(); hw(16'h130, 8'h31); tick(); hw(16'h170, 8'h4B); cr(16'h7F01);
    // R11: command collision, then reply collision
    tag = "R11";
    hw(16'h170, 8'h10);
    host_addr = 10'h170; host_wdata = 8'h20; host_wr = 1; cp_addr = 16'h7F11; cp_rd = 1;
    tick(); clear_in();
    cr(16'h7F22); tick();
    cw(16'h7F00, 8'h61);
    host_addr = 10'h170; host_rd = 1; cp_addr = 16'h7FAA; cp_wdata = 8'h62; cp_wr = 1;
    tick(); clear_in();
    hr(16'h171); hr(16'h170); hr(16'h171);
    // reset clears pending state
    tag = "R10"; hw(16'h170, 8'h55); cw(16'h7F00, 8'h66);
    do_reset(4'd0);
    hr(16'h101); tick();
    window_pass(16'h100);
    do_reset(4'd15);
    tag = "R10"; hr(16'h1F1);
    window_pass(16'h1F0);
    done = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog (%s): actual=still running expected=finished", tag);
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule